// File: doc/BRIEF.md
# Microcode Address Sequencer with Prefixed Opcode Dispatch

This block produces the control-store address of a microcoded processor whose store holds 1024 microwords. It keeps the current microcode address in a register. It picks the next address from one of four sources: an opcode byte handed in from the instruction stream, a second byte that follows a prefix byte, the branch field of the current microword, or reset. While it waits for an instruction byte it raises a fetch request and holds its address steady.

The current microword feeds back four things:
- an 8-bit branch field;
- a one-bit upper-half selector;
- a bit that asks for a return to opcode fetch;
- a 4-bit miscellaneous code.

Two values of that code mark privileged work. For those values the sequencer emits a one-cycle strobe when the processor is in supervisor mode, and a trap pulse when it is not. The same two values also keep a branch in the lower half, whatever the selector bit says.

A single clock enable gates every state change, so the surrounding pipeline can stall the sequencer.

Top module: `useq_top`

## Requirements
- R1: While reset is high and on the first cycle after it, the address output is 0 and the fetch request is high.
- R2: In the fetch and prefix-wait states the fetch request is high, and the address does not change until a byte arrives with its valid bit high on an enabled clock.
- R3: A valid byte from 0x00 to 0xFE in the fetch state makes the address equal to that byte on the next cycle, and the fetch request falls.
- R4: A valid byte 0xFF in the fetch state holds the address and keeps the fetch request high for one more byte. The next valid byte B (0xFF included) then makes the address 512 + B.
- R5: In the run state, with the return-to-fetch bit clear and the selector bit 0, the next address is 256 + branch field (field 0x34 gives 308).
- R6: In the run state, with the return-to-fetch bit clear and the selector bit 1, the next address is 512 + branch field (field 0x34 gives 564).
- R7: When the miscellaneous code is 0xE or 0xF, the selector bit is treated as 0, so the branch lands in 256–511.
- R8: In the run state, the return-to-fetch bit sends the sequencer back to the fetch state with the address held. This bit takes priority over the selector bit and the branch field.
- R9: In the run state, on an enabled cycle with miscellaneous code 0xE or 0xF, priv_stb_o is high when supervisor_i is high and trap_o is high when supervisor_i is low. Both are low in every other cycle, and they are never high together.
- R10: With ce_i low, the address and state do not change, and priv_stb_o and trap_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Clock enable for all state changes |
| opcode_i | input | 8 | Instruction byte |
| opcode_valid_i | input | 1 | opcode_i carries a byte this cycle |
| uw_next_i | input | 8 | Branch field of the current microword |
| uw_ext_i | input | 1 | Upper-half selector of the current microword |
| uw_disp_i | input | 1 | Return-to-fetch request of the current microword |
| uw_misc_i | input | 4 | Miscellaneous code of the current microword |
| supervisor_i | input | 1 | Processor is in supervisor mode |
| ua_o | output | 10 | Control-store address |
| fetch_req_o | output | 1 | Sequencer wants an instruction byte |
| priv_stb_o | output | 1 | Privileged operation strobe |
| trap_o | output | 1 | Privileged code seen outside supervisor mode |

## Verification
The hardest overlap is a privileged miscellaneous code in the same microword as an upper-half selector or a return-to-fetch bit. In that cycle the strobe or trap must fire while the branch is pulled into the lower half, or while the return to fetch still wins. Directed microwords set these fields together, and random stimulus crosses them with supervisor mode and stalls. A cycle-level model in the bench, built from the requirements, predicts both the address on the next cycle and the strobe and trap outputs in the present cycle.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UA_W   = 10;
    localparam int OP_W   = 8;
    localparam int MISC_W = 4;

    localparam logic [OP_W-1:0]   PREFIX_CODE = 8'hFF;
    localparam logic [MISC_W-1:0] MISC_PRIV_A = 4'hE;
    localparam logic [MISC_W-1:0] MISC_PRIV_B = 4'hF;

    typedef enum logic [1:0] {
        SQ_FETCH  = 2'd0,
        SQ_PREFIX = 2'd1,
        SQ_RUN    = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic [OP_W-1:0]   nxt;
        logic              ext;
        logic              disp;
        logic [MISC_W-1:0] misc;
    } uword_t;

    function automatic logic is_priv_code(input logic [MISC_W-1:0] m);
        return (m == MISC_PRIV_A) || (m == MISC_PRIV_B);
    endfunction

endpackage

// File: rtl/useq_priv_dec.sv
module useq_priv_dec
    import useq_pkg::*;
(
    input  logic              ce,
    input  logic              running,
    input  logic [MISC_W-1:0] misc,
    input  logic              supervisor,
    output logic              priv_code,
    output logic              priv_stb,
    output logic              trap
);
    logic fire;

    always_comb begin
        priv_code = is_priv_code(misc);
        fire      = ce && running && priv_code;
        priv_stb  = fire && supervisor;
        trap      = fire && !supervisor;
    end
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  sq_state_e       st_q,
    input  logic [UA_W-1:0] ua_q,
    input  logic [OP_W-1:0] opcode,
    input  logic            opcode_valid,
    input  uword_t          uw,
    input  logic            priv_code,
    output sq_state_e       st_d,
    output logic [UA_W-1:0] ua_d
);
    localparam int PAD_W = UA_W - OP_W;
    localparam logic [UA_W-1:0] BRANCH_BASE = UA_W'(1) << OP_W;
    localparam logic [UA_W-1:0] UPPER_BASE  = UA_W'(1) << (UA_W - 1);

    logic [UA_W-1:0] op_wide;
    logic [UA_W-1:0] nxt_wide;
    logic            ext_eff;

    always_comb begin
        op_wide  = {{PAD_W{1'b0}}, opcode};
        nxt_wide = {{PAD_W{1'b0}}, uw.nxt};
        ext_eff  = uw.ext && !priv_code;
        st_d     = st_q;
        ua_d     = ua_q;
        unique case (st_q)
            SQ_FETCH: begin
                if (opcode_valid) begin
                    if (opcode == PREFIX_CODE) begin
                        st_d = SQ_PREFIX;
                    end else begin
                        st_d = SQ_RUN;
                        ua_d = op_wide;
                    end
                end
            end
            SQ_PREFIX: begin
                if (opcode_valid) begin
                    st_d = SQ_RUN;
                    ua_d = UPPER_BASE + op_wide;
                end
            end
            SQ_RUN: begin
                if (uw.disp) begin
                    st_d = SQ_FETCH;
                end else if (ext_eff) begin
                    ua_d = UPPER_BASE + nxt_wide;
                end else begin
                    ua_d = BRANCH_BASE + nxt_wide;
                end
            end
            default: st_d = SQ_FETCH;
        endcase
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_i,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic              opcode_valid_i,
    input  logic [OP_W-1:0]   uw_next_i,
    input  logic              uw_ext_i,
    input  logic              uw_disp_i,
    input  logic [MISC_W-1:0] uw_misc_i,
    input  logic              supervisor_i,
    output logic [UA_W-1:0]   ua_o,
    output logic              fetch_req_o,
    output logic              priv_stb_o,
    output logic              trap_o
);
    sq_state_e       st_q, st_d;
    logic [UA_W-1:0] ua_q, ua_d;
    uword_t          uw;
    logic            priv_code;

    always_comb begin
        uw.nxt  = uw_next_i;
        uw.ext  = uw_ext_i;
        uw.disp = uw_disp_i;
        uw.misc = uw_misc_i;
    end

    useq_priv_dec u_priv (
        .ce         (ce_i),
        .running    (st_q == SQ_RUN),
        .misc       (uw_misc_i),
        .supervisor (supervisor_i),
        .priv_code  (priv_code),
        .priv_stb   (priv_stb_o),
        .trap       (trap_o)
    );

    useq_next u_next (
        .st_q         (st_q),
        .ua_q         (ua_q),
        .opcode       (opcode_i),
        .opcode_valid (opcode_valid_i),
        .uw           (uw),
        .priv_code    (priv_code),
        .st_d         (st_d),
        .ua_d         (ua_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SQ_FETCH;
            ua_q <= '0;
        end else if (ce_i) begin
            st_q <= st_d;
            ua_q <= ua_d;
        end
    end

    assign ua_o        = ua_q;
    assign fetch_req_o = (st_q != SQ_RUN);
endmodule

// File: rtl/useq_chk.sv
module useq_chk
    import useq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce_i,
    input logic [OP_W-1:0]   opcode_i,
    input logic              opcode_valid_i,
    input logic [OP_W-1:0]   uw_next_i,
    input logic              uw_ext_i,
    input logic              uw_disp_i,
    input logic [MISC_W-1:0] uw_misc_i,
    input logic              supervisor_i,
    input logic [UA_W-1:0]   ua_o,
    input logic              fetch_req_o,
    input logic              priv_stb_o,
    input logic              trap_o,
    input sq_state_e         st_q
);
    logic pc;
    assign pc = (uw_misc_i == 4'hE) || (uw_misc_i == 4'hF);

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_FETCH && !opcode_valid_i) |=> (fetch_req_o && $stable(ua_o))); // R2

    AST_DIRECT_DISPATCH: assert property (@(posedge clk) disable iff (rst)
        (ce_i && st_q == SQ_FETCH && opcode_valid_i && opcode_i != 8'hFF)
        |=> (ua_o == {2'b00, $past(opcode_i)} && !fetch_req_o)); // R3

    AST_PREFIX_DISPATCH: assert property (@(posedge clk) disable iff (rst)
        (ce_i && st_q == SQ_PREFIX && opcode_valid_i)
        |=> (ua_o == {2'b10, $past(opcode_i)})); // R4

    AST_LOWER_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (ce_i && st_q == SQ_RUN && !uw_disp_i && !uw_ext_i)
        |=> (ua_o == {2'b01, $past(uw_next_i)})); // R5

    AST_UPPER_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (ce_i && st_q == SQ_RUN && !uw_disp_i && uw_ext_i && !pc)
        |=> (ua_o == {2'b10, $past(uw_next_i)})); // R6

    AST_PRIV_FORCES_LOWER: assert property (@(posedge clk) disable iff (rst)
        (ce_i && st_q == SQ_RUN && !uw_disp_i && pc) |=> (ua_o[9:8] == 2'b01)); // R7

    AST_DISPATCH_WINS: assert property (@(posedge clk) disable iff (rst)
        (ce_i && st_q == SQ_RUN && uw_disp_i) |=> (fetch_req_o && $stable(ua_o))); // R8

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(priv_stb_o && trap_o)); // R9

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !ce_i |=> ($stable(ua_o) && $stable(fetch_req_o))); // R10

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ce_i |-> (!priv_stb_o && !trap_o)); // R10
endmodule

bind useq_top useq_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .ce_i           (ce_i),
    .opcode_i       (opcode_i),
    .opcode_valid_i (opcode_valid_i),
    .uw_next_i      (uw_next_i),
    .uw_ext_i       (uw_ext_i),
    .uw_disp_i      (uw_disp_i),
    .uw_misc_i      (uw_misc_i),
    .supervisor_i   (supervisor_i),
    .ua_o           (ua_o),
    .fetch_req_o    (fetch_req_o),
    .priv_stb_o     (priv_stb_o),
    .trap_o         (trap_o),
    .st_q           (st_q)
);

// File: tb/useq_top_tb_top.sv
`timescale 1ns/1ps
module useq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_i = 1'b0;
    logic [7:0] opcode_i = '0;
    logic       opcode_valid_i = 1'b0;
    logic [7:0] uw_next_i = '0;
    logic       uw_ext_i = 1'b0;
    logic       uw_disp_i = 1'b0;
    logic [3:0] uw_misc_i = '0;
    logic       supervisor_i = 1'b1;
    logic [9:0] ua_o;
    logic       fetch_req_o, priv_stb_o, trap_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model: 0 fetch, 1 prefix wait, 2 run
    int         m_st = 0;
    logic [9:0] m_ua = '0;
    string      m_tag = "R1";

    always #4 clk = ~clk;

    useq_top dut_i (
        .clk(clk), .rst(rst), .ce_i(ce_i), .opcode_i(opcode_i),
        .opcode_valid_i(opcode_valid_i), .uw_next_i(uw_next_i),
        .uw_ext_i(uw_ext_i), .uw_disp_i(uw_disp_i), .uw_misc_i(uw_misc_i),
        .supervisor_i(supervisor_i), .ua_o(ua_o), .fetch_req_o(fetch_req_o),
        .priv_stb_o(priv_stb_o), .trap_o(trap_o)
    );

    function automatic bit priv_of(input logic [3:0] m);
        return (m == 4'hE) || (m == 4'hF);
    endfunction

    function automatic logic [9:0] branch_of(input logic [7:0] f, input logic e, input logic [3:0] m);
        return (e && !priv_of(m)) ? (10'd512 + {2'b00, f}) : (10'd256 + {2'b00, f});
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic ce, input logic vld, input logic [7:0] op,
                        input logic [7:0] nxt, input logic ext, input logic disp,
                        input logic [3:0] misc, input logic sup);
        bit run;
        bit pc;
        @(negedge clk);
        chk({m_tag, " address"}, int'(ua_o), int'(m_ua));
        ce_i = ce; opcode_valid_i = vld; opcode_i = op;
        uw_next_i = nxt; uw_ext_i = ext; uw_disp_i = disp; uw_misc_i = misc;
        supervisor_i = sup;
        #1;
        run = (m_st == 2);
        pc  = priv_of(misc);
        chk(run ? "R3 fetch_req" : "R2 fetch_req", int'(fetch_req_o), int'(!run));
        chk(ce ? "R9 priv_stb" : "R10 priv_stb", int'(priv_stb_o), int'(ce && run && pc && sup));
        chk(ce ? "R9 trap" : "R10 trap", int'(trap_o), int'(ce && run && pc && !sup));
        if (!ce) begin
            m_tag = "R10";
        end else if (m_st == 0) begin
            if (!vld) m_tag = "R2";
            else if (op == 8'hFF) begin m_st = 1; m_tag = "R4"; end
            else begin m_st = 2; m_ua = {2'b00, op}; m_tag = "R3"; end
        end else if (m_st == 1) begin
            if (!vld) m_tag = "R2";
            else begin m_st = 2; m_ua = 10'd512 + {2'b00, op}; m_tag = "R4"; end
        end else begin
            if (disp) begin m_st = 0; m_tag = "R8"; end
            else begin
                m_ua = branch_of(nxt, ext, misc);
                m_tag = (pc && ext) ? "R7" : (ext ? "R6" : "R5");
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 address in reset", int'(ua_o), 0);
        chk("R1 fetch_req in reset", int'(fetch_req_o), 1);
        rst = 1'b0;
        m_st = 0; m_ua = '0; m_tag = "R1";

        // R2: no byte yet, then stall with valid byte
        step(1, 0, 8'h12, 8'h00, 0, 0, 4'h0, 1);
        step(0, 1, 8'h12, 8'h00, 0, 0, 4'h0, 1);
        // R3 direct dispatch, then R5/R6 with field 0x34
        step(1, 1, 8'h12, 8'h00, 0, 0, 4'h0, 1);
        step(1, 0, 8'h00, 8'h34, 0, 0, 4'h0, 1);
        step(1, 0, 8'h00, 8'h34, 1, 0, 4'h0, 1);
        // R7 privileged code with ext set, supervisor high (R9 strobe)
        step(1, 0, 8'h00, 8'h34, 1, 0, 4'hE, 1);
        // R9 trap, supervisor low, ext set on 0xF
        step(1, 0, 8'h00, 8'hA0, 1, 0, 4'hF, 0);
        // R10 stall in run with privileged code: no strobe
        step(0, 0, 8'h00, 8'h55, 1, 0, 4'hE, 1);
        // R8 dispatch wins over ext, with privileged code too
        step(1, 0, 8'h00, 8'h77, 1, 1, 4'hE, 1);
        // R4 prefix then 0xFF as extended opcode -> 767
        step(1, 1, 8'hFF, 8'h00, 0, 0, 4'h0, 1);
        step(1, 0, 8'h00, 8'h00, 0, 0, 4'h0, 1);
        step(1, 1, 8'hFF, 8'h00, 0, 0, 4'h0, 1);
        step(1, 0, 8'h00, 8'h00, 0, 1, 4'h0, 1);
        // R3 boundary 0xFE and 0x00
        step(1, 1, 8'hFE, 8'h00, 0, 0, 4'h0, 1);
        step(1, 0, 8'h00, 8'hFF, 1, 1, 4'h0, 1);
        step(1, 1, 8'h00, 8'h00, 0, 0, 4'h0, 1);
        step(1, 0, 8'h00, 8'hFF, 1, 0, 4'h0, 1);

        for (int i = 0; i < 4000; i++) begin
            logic [7:0] op;
            op = ($urandom % 6 == 0) ? 8'hFF : 8'($urandom);
            step(($urandom % 10) != 0, ($urandom % 5) < 3, op, 8'($urandom),
                 1'($urandom), ($urandom % 6) == 0, 4'($urandom),
                 ($urandom % 4) != 0);
        end
        @(negedge clk);
        chk({m_tag, " address"}, int'(ua_o), int'(m_ua));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule